// File: doc/BRIEF.md
# Permissioned Set-Associative Tag Directory

This block keeps the tag side of a set-associative cache. For every way of every set it holds a line address, a two-bit access permission and the context id that owns a lock on the line. It stores no line data. A coherence controller sends it one command per cycle. The commands cover access checks, presence probes, allocation and release of ways, permission changes, lock handling and victim selection. The answer comes back exactly one cycle later. Replacement order inside each set is tracked by a binary-tree pseudo-LRU.

The set index sits in the address bits just above the line offset. The tag is every bit above the index. Only line-aligned addresses are meaningful, and the offset bits are ignored. Capacity, associativity, line size, address width and context-id width are parameters. The number of sets is derived from them. A command that cannot be performed does not stop the run. It raises `rsp_err` and leaves the directory unchanged.

Top module: `perm_tag_dir`

## Requirements
- R1: `cmd_ready` is low in reset and high from the first clock after reset. A command taken while `cmd_valid` and `cmd_ready` are both high gives `rsp_valid` high for exactly the next cycle, and `rsp_valid` is low in any cycle after a clock where no command was taken. Op codes are: 0 access, 1 present, 2 present-ignoring-permission, 3 available, 4 allocate, 5 release, 6 set permission, 7 lock, 8 unlock, 9 lock test, 10 victim. Any other code is an error.
- R2: With the default parameters (1024 bytes, 4 ways, 64-byte lines) there are 4 sets, indexed by address bits [7:6], and the tag is bits [31:8]. Equal tags in different sets are independent entries.
- R3: Permission codes are 0 not-present, 1 invalid, 2 read-only and 3 read-write. The present op (1) reports a miss for a way whose permission is not-present. Op 2 reports a match whatever the permission and returns that permission on `rsp_perm`.
- R4: An access (op 0) hits when the permission is read-write, for any request kind. With read-only it hits only for loads and fetches. Every other case misses. Request kinds are 0 load, 1 fetch and 2 store.
- R5: An access that finds the tag marks that way most recently used, even when the permission denies it. Probe, lock, permission and victim ops leave the replacement state alone.
- R6: The available op (3) returns 1 when the tag already sits in the set, or when any way is empty or not-present.
- R7: Allocate takes the lowest-numbered way that is empty or not-present. It writes the tag, sets the permission to invalid, clears the lock, marks the way most recently used and returns the way on `rsp_way`.
- R8: Allocate of a tag that is present, or into a set with no free way, sets `rsp_err` and changes nothing.
- R9: Release empties the matching way and clears its lock, so later probes of that line miss.
- R10: Set permission writes `cmd_perm`. Any new value other than read-write clears the lock, and read-write keeps it.
- R11: Lock stores `cmd_ctx` as the owner and unlock stores all-ones, which means unowned. The lock test returns 1 exactly when the stored owner equals `cmd_ctx`.
- R12: The victim op sets `rsp_err` if the set is available. Otherwise it returns the way picked by the tree and that way's line address. Each set has WAYS-1 node bits. A touch sets every node on the way's path to point at the other subtree. The victim walks from the root following the pointers, where 0 means the lower half.
- R13: Release, set permission, lock, unlock and lock test on a line that is not present set `rsp_err` and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Directory accepts a command |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | ADDR_W | Line address |
| cmd_kind | input | 2 | Request kind for access |
| cmd_perm | input | 2 | New permission for set-permission |
| cmd_ctx | input | CTX_W | Context id for lock ops |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Boolean result of the op |
| rsp_err | output | 1 | Op could not be performed |
| rsp_way | output | WAY_W | Way found, allocated or chosen |
| rsp_perm | output | 2 | Permission of the way found, or written |
| rsp_addr | output | ADDR_W | Line address of the victim |

## Verification
Accesses are tried with all three request kinds against invalid, read-only and read-write lines. That separates the permission rule from plain tag matching. One set is filled and then refilled through a not-present way and a released way. The victim answers there show whether denied accesses and allocations move the tree, and whether the lowest free way is chosen. Lock sequences interleave set permission to read-write and to read-only, to tell a lock that is kept from one that is released. Probes of the same tag in another set, and ops on absent lines, confirm set isolation and error reporting without state change.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
   typedef enum logic [1:0] {
      PERM_ABSENT  = 2'd0,
      PERM_INVALID = 2'd1,
      PERM_READ    = 2'd2,
      PERM_WRITE   = 2'd3
   } perm_e;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'd0,
      KIND_FETCH = 2'd1,
      KIND_STORE = 2'd2
   } kind_e;

   typedef enum logic [3:0] {
      OP_ACCESS      = 4'd0,
      OP_PRESENT     = 4'd1,
      OP_PRESENT_RAW = 4'd2,
      OP_AVAIL       = 4'd3,
      OP_ALLOC       = 4'd4,
      OP_FREE        = 4'd5,
      OP_SETPERM     = 4'd6,
      OP_LOCK        = 4'd7,
      OP_UNLOCK      = 4'd8,
      OP_LOCKTEST    = 4'd9,
      OP_VICTIM      = 4'd10
   } op_e;
endpackage

// File: rtl/tagdir_prio.sv
module tagdir_prio #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/tagdir_match.sv
module tagdir_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 24,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            way_vld,
   input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [WAYS-1:0][1:0]       way_perm,
   input  logic [TAG_W-1:0]           tag,
   output logic                       hit_any,
   output logic [WAY_W-1:0]           hit_way,
   output logic                       raw_any,
   output logic [WAY_W-1:0]           raw_way,
   output logic                       free_any,
   output logic [WAY_W-1:0]           free_way
);
   import tagdir_pkg::*;

   logic [WAYS-1:0] raw_vec, hit_vec, free_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic absent;
      assign absent      = (way_perm[w] == PERM_ABSENT);
      assign raw_vec[w]  = way_vld[w] && (way_tag[w] == tag);
      assign hit_vec[w]  = raw_vec[w] && !absent;
      assign free_vec[w] = !way_vld[w] || absent;
   end

   tagdir_prio #(.N(WAYS)) u_hit  (.req(hit_vec),  .any(hit_any),  .idx(hit_way));
   tagdir_prio #(.N(WAYS)) u_raw  (.req(raw_vec),  .any(raw_any),  .idx(raw_way));
   tagdir_prio #(.N(WAYS)) u_free (.req(free_vec), .any(free_any), .idx(free_way));
endmodule

// File: rtl/tagdir_plru.sv
module tagdir_plru #(
   parameter int SETS = 4,
   parameter int WAYS = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int LVL   = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [LVL-1:0]   touch_way,
   input  logic [SET_W-1:0] query_set,
   output logic [LVL-1:0]   victim_way
);
   // Heap-ordered node bits, node 1 is the root; bit 0 of each row is spare.
   logic [SETS-1:0][WAYS-1:0] tree_q;
   logic [WAYS-1:0]           row_nxt;
   logic [LVL:0]              walk;
   logic [LVL:0]              climb;

   always_comb begin
      walk = (LVL + 1)'(1);
      for (int l = 0; l < LVL; l++) begin
         walk = {walk[LVL-1:0], tree_q[query_set][walk[LVL-1:0]]};
      end
      victim_way = walk[LVL-1:0];
   end

   always_comb begin
      row_nxt = tree_q[touch_set];
      climb   = {1'b1, touch_way};
      for (int l = 0; l < LVL; l++) begin
         row_nxt[climb[LVL:1]] = ~climb[0];
         climb = climb >> 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tree_q <= '0;
      else if (touch_en) tree_q[touch_set] <= row_nxt;
   end
endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir #(
   parameter int ADDR_W     = 32,
   parameter int CAP_BYTES  = 1024,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 64,
   parameter int CTX_W      = 4,
   localparam int SETS  = CAP_BYTES / WAYS / LINE_BYTES,
   localparam int OFF_W = $clog2(LINE_BYTES),
   localparam int SET_W = $clog2(SETS),
   localparam int TAG_W = ADDR_W - OFF_W - SET_W,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [3:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [1:0]        cmd_kind,
   input  logic [1:0]        cmd_perm,
   input  logic [CTX_W-1:0]  cmd_ctx,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_err,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [1:0]        rsp_perm,
   output logic [ADDR_W-1:0] rsp_addr
);
   import tagdir_pkg::*;

   localparam logic [CTX_W-1:0] NO_OWNER = '1;

   if (SETS < 2) begin : g_chk_sets
      $error("perm_tag_dir: capacity must give at least two sets");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_chk_ways
      $error("perm_tag_dir: WAYS must be a power of two, at least 2");
   end
   if ((1 << OFF_W) != LINE_BYTES || (1 << SET_W) != SETS) begin : g_chk_pow
      $error("perm_tag_dir: line size and set count must be powers of two");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("perm_tag_dir: address too narrow");
   end

   // Directory state
   logic [SETS-1:0][WAYS-1:0]             vld_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][1:0]        perm_q;
   logic [SETS-1:0][WAYS-1:0][CTX_W-1:0]  lock_q;

   logic ready_q;
   logic fire;
   op_e  op;
   logic [SET_W-1:0] set_idx;
   logic [TAG_W-1:0] tag_in;

   assign cmd_ready = ready_q;
   assign fire      = cmd_valid && ready_q;
   assign op        = op_e'(cmd_op);
   assign set_idx   = cmd_addr[OFF_W +: SET_W];
   assign tag_in    = cmd_addr[ADDR_W-1 -: TAG_W];

   logic             hit_any, raw_any, free_any, avail;
   logic [WAY_W-1:0] hit_way, raw_way, free_way, victim_way;

   tagdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .way_vld  (vld_q[set_idx]),
      .way_tag  (tag_q[set_idx]),
      .way_perm (perm_q[set_idx]),
      .tag      (tag_in),
      .hit_any  (hit_any),
      .hit_way  (hit_way),
      .raw_any  (raw_any),
      .raw_way  (raw_way),
      .free_any (free_any),
      .free_way (free_way)
   );

   assign avail = raw_any || free_any;

   logic             touch_en;
   logic [WAY_W-1:0] touch_way;

   tagdir_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_set  (set_idx),
      .touch_way  (touch_way),
      .query_set  (set_idx),
      .victim_way (victim_way)
   );

   // Command decode
   logic              r_hit, r_err;
   logic [WAY_W-1:0]  r_way;
   logic [1:0]        r_perm;
   logic [ADDR_W-1:0] r_addr;
   logic              do_alloc, do_free, do_perm, do_lock;
   logic [CTX_W-1:0]  lock_val;
   logic [1:0]        hit_perm;

   assign hit_perm = perm_q[set_idx][hit_way];

   always_comb begin
      r_hit     = 1'b0;
      r_err     = 1'b0;
      r_way     = hit_way;
      r_perm    = hit_any ? hit_perm : PERM_ABSENT;
      r_addr    = '0;
      do_alloc  = 1'b0;
      do_free   = 1'b0;
      do_perm   = 1'b0;
      do_lock   = 1'b0;
      lock_val  = NO_OWNER;
      touch_en  = 1'b0;
      touch_way = hit_way;
      unique case (op)
         OP_ACCESS: begin
            r_hit    = hit_any && ((hit_perm == PERM_WRITE) ||
                       ((hit_perm == PERM_READ) && (cmd_kind != KIND_STORE)));
            touch_en = fire && hit_any;
         end
         OP_PRESENT: r_hit = hit_any;
         OP_PRESENT_RAW: begin
            r_hit  = raw_any;
            r_way  = raw_way;
            r_perm = raw_any ? perm_q[set_idx][raw_way] : PERM_ABSENT;
         end
         OP_AVAIL: r_hit = avail;
         OP_ALLOC: begin
            r_err     = hit_any || !free_any;
            r_hit     = !r_err;
            r_way     = free_way;
            r_perm    = PERM_INVALID;
            do_alloc  = !r_err;
            touch_en  = fire && !r_err;
            touch_way = free_way;
         end
         OP_FREE: begin
            r_err   = !hit_any;
            do_free = hit_any;
         end
         OP_SETPERM: begin
            r_err    = !hit_any;
            r_perm   = cmd_perm;
            do_perm  = hit_any;
            do_lock  = hit_any && (cmd_perm != PERM_WRITE);
         end
         OP_LOCK: begin
            r_err    = !hit_any;
            do_lock  = hit_any;
            lock_val = cmd_ctx;
         end
         OP_UNLOCK: begin
            r_err   = !hit_any;
            do_lock = hit_any;
         end
         OP_LOCKTEST: begin
            r_err = !hit_any;
            r_hit = hit_any && (lock_q[set_idx][hit_way] == cmd_ctx);
         end
         OP_VICTIM: begin
            r_err  = avail;
            r_way  = victim_way;
            r_perm = perm_q[set_idx][victim_way];
            r_addr = {tag_q[set_idx][victim_way], set_idx, {OFF_W{1'b0}}};
         end
         default: r_err = 1'b1;
      endcase
   end

   // State update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         tag_q  <= '0;
         perm_q <= '0;
         lock_q <= {SETS*WAYS{NO_OWNER}};
      end else if (fire) begin
         if (do_alloc) begin
            vld_q[set_idx][free_way]  <= 1'b1;
            tag_q[set_idx][free_way]  <= tag_in;
            perm_q[set_idx][free_way] <= PERM_INVALID;
            lock_q[set_idx][free_way] <= NO_OWNER;
         end
         if (do_free) begin
            vld_q[set_idx][hit_way]  <= 1'b0;
            perm_q[set_idx][hit_way] <= PERM_ABSENT;
            lock_q[set_idx][hit_way] <= NO_OWNER;
         end
         if (do_perm) perm_q[set_idx][hit_way] <= cmd_perm;
         if (do_lock) lock_q[set_idx][hit_way] <= lock_val;
      end
   end

   // Response register
   op_e              op_q;
   logic [SET_W-1:0] set_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_way   <= '0;
         rsp_perm  <= '0;
         rsp_addr  <= '0;
         op_q      <= OP_ACCESS;
         set_q     <= '0;
      end else begin
         ready_q   <= 1'b1;
         rsp_valid <= fire;
         if (fire) begin
            rsp_hit  <= r_hit;
            rsp_err  <= r_err;
            rsp_way  <= r_way;
            rsp_perm <= r_perm;
            rsp_addr <= r_addr;
            op_q     <= op;
            set_q    <= set_idx;
         end
      end
   end

   // Assertions
   assert_rsp_follows_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_valid);
   assert_no_rsp_without_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !rsp_valid);
   assert_access_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && op_q == OP_ACCESS && rsp_hit) |->
      (rsp_perm == PERM_WRITE || rsp_perm == PERM_READ));
   assert_alloc_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && op_q == OP_ALLOC && !rsp_err) |->
      (vld_q[set_q][rsp_way] && perm_q[set_q][rsp_way] == PERM_INVALID &&
       lock_q[set_q][rsp_way] == NO_OWNER));
   assert_free_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && op_q == OP_FREE && !rsp_err) |-> !vld_q[set_q][rsp_way]);
   assert_perm_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && op_q == OP_SETPERM && !rsp_err && rsp_perm != PERM_WRITE) |->
      (lock_q[set_q][rsp_way] == NO_OWNER));
   assert_victim_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && op_q == OP_VICTIM && !rsp_err) |-> (&vld_q[set_q]));
endmodule

// File: tb/perm_tag_dir_tb.sv
`timescale 1ns/1ps
module perm_tag_dir_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [3:0]  cmd_op = '0;
   logic [31:0] cmd_addr = '0;
   logic [1:0]  cmd_kind = '0;
   logic [1:0]  cmd_perm = '0;
   logic [3:0]  cmd_ctx = '0;
   logic        rsp_valid, rsp_hit, rsp_err;
   logic [1:0]  rsp_way, rsp_perm;
   logic [31:0] rsp_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   perm_tag_dir u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_kind(cmd_kind),
      .cmd_perm(cmd_perm), .cmd_ctx(cmd_ctx), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_way(rsp_way),
      .rsp_perm(rsp_perm), .rsp_addr(rsp_addr)
   );

   localparam logic [3:0] ACC = 0, PRS = 1, RAW = 2, AVL = 3, ALC = 4, FRE = 5,
                          SPM = 6, LCK = 7, ULK = 8, LTS = 9, VIC = 10;

   function automatic logic [31:0] la(input int tag, input int set);
      return {tag[23:0], set[1:0], 6'b0};
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [3:0] op, input logic [31:0] a,
                      input logic [1:0] kind = 0, input logic [1:0] perm = 0,
                      input logic [3:0] ctx = 0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
      cmd_kind = kind; cmd_perm = perm; cmd_ctx = ctx;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R1 rsp_valid", rsp_valid, 1);
   endtask

   task automatic t_reset;
      #5;
      chk("R1 ready in reset", cmd_ready, 0);
      chk("R1 rsp_valid in reset", rsp_valid, 0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", cmd_ready, 1);
   endtask

   task automatic t_empty;
      cmd(PRS, la(1, 0));  chk("R3 empty probe", rsp_hit, 0);
      cmd(AVL, la(1, 0));  chk("R6 empty set available", rsp_hit, 1);
      cmd(ALC, la(1, 0));
      chk("R7 alloc way", rsp_way, 0); chk("R7 alloc err", rsp_err, 0);
      chk("R7 alloc perm", rsp_perm, 1);
      cmd(PRS, la(1, 0));  chk("R3 invalid line is present", rsp_hit, 1);
      cmd(PRS, la(1, 1));  chk("R2 other set independent", rsp_hit, 0);
   endtask

   task automatic t_access;
      cmd(ACC, la(1, 0), 0); chk("R4 load on invalid", rsp_hit, 0);
      cmd(SPM, la(1, 0), 0, 2);
      cmd(ACC, la(1, 0), 0); chk("R4 load on read-only", rsp_hit, 1);
      cmd(ACC, la(1, 0), 1); chk("R4 fetch on read-only", rsp_hit, 1);
      cmd(ACC, la(1, 0), 2); chk("R4 store on read-only", rsp_hit, 0);
      chk("R4 perm returned", rsp_perm, 2);
      cmd(SPM, la(1, 0), 0, 3);
      cmd(ACC, la(1, 0), 2); chk("R4 store on read-write", rsp_hit, 1);
   endtask

   task automatic t_lock;
      cmd(LCK, la(1, 0), 0, 0, 5);
      cmd(LTS, la(1, 0), 0, 0, 5); chk("R11 owner matches", rsp_hit, 1);
      cmd(LTS, la(1, 0), 0, 0, 3); chk("R11 other ctx", rsp_hit, 0);
      cmd(SPM, la(1, 0), 0, 3);
      cmd(LTS, la(1, 0), 0, 0, 5); chk("R10 read-write keeps lock", rsp_hit, 1);
      cmd(SPM, la(1, 0), 0, 2);
      cmd(LTS, la(1, 0), 0, 0, 5); chk("R10 read-only drops lock", rsp_hit, 0);
      cmd(LTS, la(1, 0), 0, 0, 15); chk("R11 unowned is all-ones", rsp_hit, 1);
      cmd(LCK, la(1, 0), 0, 0, 7);
      cmd(ULK, la(1, 0));
      cmd(LTS, la(1, 0), 0, 0, 7); chk("R11 unlock", rsp_hit, 0);
   endtask

   task automatic t_fill;
      cmd(ALC, la(1, 0)); chk("R8 alloc of present tag", rsp_err, 1);
      cmd(ALC, la(2, 0)); chk("R7 second way", rsp_way, 1);
      cmd(ALC, la(3, 0)); chk("R7 third way", rsp_way, 2);
      cmd(ALC, la(4, 0)); chk("R7 fourth way", rsp_way, 3);
      cmd(AVL, la(5, 0)); chk("R6 full set", rsp_hit, 0);
      cmd(AVL, la(2, 0)); chk("R6 matching tag", rsp_hit, 1);
      cmd(ALC, la(5, 0)); chk("R8 alloc into full set", rsp_err, 1);
      cmd(PRS, la(5, 0)); chk("R8 failed alloc left nothing", rsp_hit, 0);
      cmd(VIC, la(5, 0));
      chk("R12 victim err", rsp_err, 0); chk("R12 victim way", rsp_way, 0);
      chk("R12 victim addr", rsp_addr, la(1, 0));
      cmd(ACC, la(2, 0), 0); chk("R5 denied access", rsp_hit, 0);
      cmd(VIC, la(5, 0));
      chk("R5 denied access touches", rsp_way, 2);
      chk("R12 victim addr after touch", rsp_addr, la(3, 0));
   endtask

   task automatic t_refill;
      cmd(SPM, la(3, 0), 0, 0);
      cmd(PRS, la(3, 0)); chk("R3 not-present is a miss", rsp_hit, 0);
      cmd(RAW, la(3, 0));
      chk("R3 raw probe finds", rsp_hit, 1); chk("R3 raw perm", rsp_perm, 0);
      chk("R3 raw way", rsp_way, 2);
      cmd(AVL, la(5, 0)); chk("R6 not-present way frees set", rsp_hit, 1);
      cmd(VIC, la(5, 0)); chk("R12 victim on available set", rsp_err, 1);
      cmd(ALC, la(5, 0)); chk("R7 reuse not-present way", rsp_way, 2);
      cmd(FRE, la(2, 0)); chk("R9 release", rsp_err, 0);
      cmd(PRS, la(2, 0)); chk("R9 released line gone", rsp_hit, 0);
      cmd(RAW, la(2, 0)); chk("R9 raw probe misses", rsp_hit, 0);
      cmd(ALC, la(6, 0)); chk("R7 reuse empty way", rsp_way, 1);
      cmd(VIC, la(7, 0));
      chk("R12 victim after refill", rsp_way, 3);
      chk("R12 victim addr after refill", rsp_addr, la(4, 0));
   endtask

   task automatic t_errors;
      cmd(FRE, la(9, 2)); chk("R13 release missing", rsp_err, 1);
      cmd(SPM, la(9, 2), 0, 3); chk("R13 perm missing", rsp_err, 1);
      cmd(LCK, la(9, 2), 0, 0, 1); chk("R13 lock missing", rsp_err, 1);
      cmd(LTS, la(9, 2), 0, 0, 1); chk("R13 lock test missing", rsp_err, 1);
      cmd(PRS, la(9, 2)); chk("R13 nothing created", rsp_hit, 0);
      cmd(4'd15, la(1, 0)); chk("R1 unknown op", rsp_err, 1);
   endtask

   task automatic t_idle;
      @(negedge clk);
      cmd_op = ALC; cmd_addr = la(8, 3);
      @(negedge clk);
      chk("R1 no command no response", rsp_valid, 0);
      cmd(PRS, la(8, 3)); chk("R1 idle command ignored", rsp_hit, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset;
      t_empty;
      t_access;
      t_lock;
      t_fill;
      t_refill;
      t_errors;
      t_idle;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule